// File: doc/BRIEF.md
# Parallel Header Rule Matcher with Payload Gate

This block takes one parsed header record per packet and tests it against every stored header rule at once. Each rule slot keeps a value, a per-bit care mask and an enable bit. Cleared mask bits are wildcards. All slots are evaluated in the same cycle. The lowest-numbered slot that hits is reported as the match index.

The block also uses an anomaly flag from a separate header analyser. When that flag is raised, the rule comparison for the packet is skipped. The match result, the anomaly flag and the record's validity together form a per-packet verdict. That verdict controls a payload gate. The gate either forwards the payload words unchanged or swaps each word for an all-zero idle word. The beat count and the end-of-packet marker are kept, so downstream framing does not change. The verdict (match flag, match index, protection status) is registered and marked by a one-cycle result strobe, so that a reporting stage can count it.

Rules are loaded through a plain write port, one slot per cycle. There is no read-back.

Top module: `hdr_rule_gate`

## Requirements
- R1: After reset, `res_strobe`, `res_matched`, `res_match_id` and `pl_out_valid` are 0, and `res_protect` is 1.
- R2: A cycle with `rule_wr_en`=1 stores value, mask and enable into slot `rule_wr_idx`. Records presented from the next cycle on are compared against the new contents. After reset every slot is disabled.
- R3: A slot hits when its enable bit is 1 and, for every bit where its mask is 1, the record bit equals the value bit. Bits with mask 0 never affect the result.
- R4: A slot whose enable bit is 0 never hits, whatever its value and mask.
- R5: When one or more slots hit, `res_matched`=1 and `res_match_id` holds the binary index of the lowest-numbered hitting slot. All `N_RULES` slots, including the highest index, take part in each evaluation.
- R6: When no slot hits, `res_matched`=0 and `res_match_id`=0.
- R7: When `hdr_anomaly`=1 with the record, comparison is skipped: `res_matched`=0 and `res_match_id`=0, whatever the rules hold.
- R8: `res_protect`=0 only when the packet is unmatched, not anomalous and `hdr_valid`=1. In every other case `res_protect`=1.
- R9: A record presented with `hdr_strobe`=1 at one rising edge has its verdict on the outputs after that edge. `res_strobe` is 1 for exactly that one cycle. The verdict outputs hold until the next record.
- R10: Each payload beat appears on the output one cycle after it enters, with the same valid and last flags. Its data is unchanged if the most recent verdict has `res_protect`=0, and all zero otherwise. Beats before any verdict are zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_wr_en | input | 1 | Rule slot write strobe |
| rule_wr_idx | input | ID_W (5) | Slot index to write |
| rule_wr_value | input | REC_W (120) | Rule compare value |
| rule_wr_mask | input | REC_W (120) | Rule care mask, 1 = compare bit |
| rule_wr_enable | input | 1 | Rule slot enable |
| hdr_strobe | input | 1 | Header record present this cycle |
| hdr_record | input | REC_W (120) | Parsed header record |
| hdr_valid | input | 1 | Record parsed as a valid packet |
| hdr_anomaly | input | 1 | Analyser flagged the packet |
| res_strobe | output | 1 | One-cycle marker of a new verdict |
| res_matched | output | 1 | A rule hit |
| res_match_id | output | ID_W (5) | Index of lowest hitting rule |
| res_protect | output | 1 | 1 = payload replaced by idle words |
| pl_in_valid | input | 1 | Payload beat valid |
| pl_in_data | input | DATA_W (64) | Payload beat data |
| pl_in_last | input | 1 | Last beat of packet |
| pl_out_valid | output | 1 | Gated beat valid |
| pl_out_data | output | DATA_W (64) | Gated beat data |
| pl_out_last | output | 1 | Gated last-beat flag |

## Verification
The assertions take three things for granted. First, control inputs are known whenever `hdr_strobe` or `pl_in_valid` is high. Second, a record and its payload never overlap in the same cycle. Third, payload beats of a packet enter only after that packet's verdict is out. The bench keeps to this by driving every input half a cycle away from the rising edge. It sends each record as a single-cycle strobe, waits for the verdict, and only then streams that packet's beats. It sweeps every combination of anomaly and validity over a range of record bytes that hits single rules, overlapping rules, a disabled slot, the top slot and no rule. It computes each expected verdict from its own copy of the rule table.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
  localparam int unsigned DEF_REC_W   = 120;
  localparam int unsigned DEF_N_RULES = 20;
  localparam int unsigned DEF_DATA_W  = 64;

  typedef struct packed {
    logic matched;
    logic protect;
  } verdict_t;
endpackage

// File: rtl/hrg_rule_store.sv
module hrg_rule_store #(
  parameter int unsigned N_RULES = 20,
  parameter int unsigned REC_W   = 120,
  parameter int unsigned ID_W    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ID_W-1:0]          wr_idx,
  input  logic [REC_W-1:0]         wr_value,
  input  logic [REC_W-1:0]         wr_mask,
  input  logic                     wr_enable,
  output logic [N_RULES*REC_W-1:0] val_flat,
  output logic [N_RULES*REC_W-1:0] mask_flat,
  output logic [N_RULES-1:0]       en_vec
);
  for (genvar g = 0; g < N_RULES; g++) begin : g_slot
    logic slot_ce;
    assign slot_ce = wr_en && (wr_idx == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_flat[g*REC_W +: REC_W]  <= '0;
        mask_flat[g*REC_W +: REC_W] <= '0;
        en_vec[g]                   <= 1'b0;
      end else if (slot_ce) begin
        val_flat[g*REC_W +: REC_W]  <= wr_value & wr_mask;
        mask_flat[g*REC_W +: REC_W] <= wr_mask;
        en_vec[g]                   <= wr_enable;
      end
    end
  end
endmodule

// File: rtl/hrg_cmp_array.sv
module hrg_cmp_array #(
  parameter int unsigned N_RULES = 20,
  parameter int unsigned REC_W   = 120
) (
  input  logic [REC_W-1:0]         record,
  input  logic [N_RULES*REC_W-1:0] val_flat,
  input  logic [N_RULES*REC_W-1:0] mask_flat,
  input  logic [N_RULES-1:0]       en_vec,
  output logic [N_RULES-1:0]       hit_vec
);
  for (genvar g = 0; g < N_RULES; g++) begin : g_cmp
    logic [REC_W-1:0] masked_rec;
    assign masked_rec = record & mask_flat[g*REC_W +: REC_W];
    assign hit_vec[g] = en_vec[g] && (masked_rec == val_flat[g*REC_W +: REC_W]);
  end
endmodule

// File: rtl/hrg_prio_enc.sv
module hrg_prio_enc #(
  parameter int unsigned N_RULES = 20,
  parameter int unsigned ID_W    = 5
) (
  input  logic [N_RULES-1:0] hit_vec,
  output logic               any_hit,
  output logic [ID_W-1:0]    hit_id
);
  always_comb begin
    hit_id = '0;
    for (int i = N_RULES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_id = ID_W'(i);
    end
  end
  assign any_hit = |hit_vec;
endmodule

// File: rtl/hrg_payload_gate.sv
module hrg_payload_gate #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block,
  input  logic              pl_in_valid,
  input  logic [DATA_W-1:0] pl_in_data,
  input  logic              pl_in_last,
  output logic              pl_out_valid,
  output logic [DATA_W-1:0] pl_out_data,
  output logic              pl_out_last
);
  logic              valid_d;
  logic [DATA_W-1:0] data_d;
  logic              last_d;

  always_comb begin
    valid_d = pl_in_valid;
    last_d  = pl_in_valid && pl_in_last;
    data_d  = (pl_in_valid && !block) ? pl_in_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_out_valid <= 1'b0;
      pl_out_data  <= '0;
      pl_out_last  <= 1'b0;
    end else begin
      pl_out_valid <= valid_d;
      pl_out_data  <= data_d;
      pl_out_last  <= last_d;
    end
  end

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_in_valid && block) |=> (pl_out_valid && pl_out_data == '0));
  assert_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pl_in_valid |=> (pl_out_valid && pl_out_last == $past(pl_in_last)));
endmodule

// File: rtl/hdr_rule_gate.sv
module hdr_rule_gate
  import hrg_pkg::*;
#(
  parameter int unsigned REC_W   = DEF_REC_W,
  parameter int unsigned N_RULES = DEF_N_RULES,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  localparam int unsigned ID_W   = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rule_wr_en,
  input  logic [ID_W-1:0]   rule_wr_idx,
  input  logic [REC_W-1:0]  rule_wr_value,
  input  logic [REC_W-1:0]  rule_wr_mask,
  input  logic              rule_wr_enable,
  input  logic              hdr_strobe,
  input  logic [REC_W-1:0]  hdr_record,
  input  logic              hdr_valid,
  input  logic              hdr_anomaly,
  output logic              res_strobe,
  output logic              res_matched,
  output logic [ID_W-1:0]   res_match_id,
  output logic              res_protect,
  input  logic              pl_in_valid,
  input  logic [DATA_W-1:0] pl_in_data,
  input  logic              pl_in_last,
  output logic              pl_out_valid,
  output logic [DATA_W-1:0] pl_out_data,
  output logic              pl_out_last
);
  logic [N_RULES*REC_W-1:0] val_flat;
  logic [N_RULES*REC_W-1:0] mask_flat;
  logic [N_RULES-1:0]       en_vec;
  logic [N_RULES-1:0]       hit_raw;
  logic [N_RULES-1:0]       hit_live;
  logic                     any_hit;
  logic [ID_W-1:0]          hit_id;

  verdict_t        vd_d, vd_q;
  logic [ID_W-1:0] id_d, id_q;
  logic            stb_q;

  hrg_rule_store #(.N_RULES(N_RULES), .REC_W(REC_W), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rule_wr_en), .wr_idx(rule_wr_idx),
    .wr_value(rule_wr_value), .wr_mask(rule_wr_mask), .wr_enable(rule_wr_enable),
    .val_flat(val_flat), .mask_flat(mask_flat), .en_vec(en_vec)
  );

  hrg_cmp_array #(.N_RULES(N_RULES), .REC_W(REC_W)) u_cmp (
    .record(hdr_record), .val_flat(val_flat), .mask_flat(mask_flat),
    .en_vec(en_vec), .hit_vec(hit_raw)
  );

  // comparison is skipped for packets the analyser already flagged
  assign hit_live = hdr_anomaly ? '0 : hit_raw;

  hrg_prio_enc #(.N_RULES(N_RULES), .ID_W(ID_W)) u_prio (
    .hit_vec(hit_live), .any_hit(any_hit), .hit_id(hit_id)
  );

  always_comb begin
    vd_d.matched = any_hit;
    vd_d.protect = any_hit || hdr_anomaly || !hdr_valid;
    id_d         = any_hit ? hit_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q      <= 1'b0;
      vd_q       <= '{matched: 1'b0, protect: 1'b1};
      id_q       <= '0;
    end else begin
      stb_q <= hdr_strobe;
      if (hdr_strobe) begin
        vd_q <= vd_d;
        id_q <= id_d;
      end
    end
  end

  assign res_strobe   = stb_q;
  assign res_matched  = vd_q.matched;
  assign res_match_id = id_q;
  assign res_protect  = vd_q.protect;

  hrg_payload_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .block(vd_q.protect),
    .pl_in_valid(pl_in_valid), .pl_in_data(pl_in_data), .pl_in_last(pl_in_last),
    .pl_out_valid(pl_out_valid), .pl_out_data(pl_out_data), .pl_out_last(pl_out_last)
  );

  assert_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_strobe |=> res_strobe);
  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_strobe |=> (!res_strobe && $stable(res_matched) && $stable(res_protect)));
  assert_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_strobe && hdr_anomaly) |=> (!res_matched && res_match_id == '0 && res_protect));
  assert_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_strobe && !hdr_valid) |=> res_protect);
  assert_match_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_matched |-> res_protect);
  assert_noid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_matched |-> (res_match_id == '0));
endmodule

// File: tb/hdr_rule_gate_bench.sv
module hdr_rule_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REC_W  = 120;
  localparam int NR     = 20;
  localparam int DW     = 64;
  localparam int IW     = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rule_wr_en = 1'b0;
  logic [IW-1:0] rule_wr_idx = '0;
  logic [REC_W-1:0] rule_wr_value = '0, rule_wr_mask = '0;
  logic rule_wr_enable = 1'b0;
  logic hdr_strobe = 1'b0, hdr_valid = 1'b0, hdr_anomaly = 1'b0;
  logic [REC_W-1:0] hdr_record = '0;
  logic res_strobe, res_matched, res_protect;
  logic [IW-1:0] res_match_id;
  logic pl_in_valid = 1'b0, pl_in_last = 1'b0;
  logic [DW-1:0] pl_in_data = '0;
  logic pl_out_valid, pl_out_last;
  logic [DW-1:0] pl_out_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic [REC_W-1:0] m_val [NR];
  logic [REC_W-1:0] m_mask[NR];
  bit               m_en  [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_rule_gate u_hdr_rule_gate (
    .clk(clk), .rst_n(rst_n),
    .rule_wr_en(rule_wr_en), .rule_wr_idx(rule_wr_idx),
    .rule_wr_value(rule_wr_value), .rule_wr_mask(rule_wr_mask),
    .rule_wr_enable(rule_wr_enable),
    .hdr_strobe(hdr_strobe), .hdr_record(hdr_record),
    .hdr_valid(hdr_valid), .hdr_anomaly(hdr_anomaly),
    .res_strobe(res_strobe), .res_matched(res_matched),
    .res_match_id(res_match_id), .res_protect(res_protect),
    .pl_in_valid(pl_in_valid), .pl_in_data(pl_in_data), .pl_in_last(pl_in_last),
    .pl_out_valid(pl_out_valid), .pl_out_data(pl_out_data), .pl_out_last(pl_out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      check(0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic write_rule(input int idx, input logic [REC_W-1:0] v,
                            input logic [REC_W-1:0] m, input bit en);
    rule_wr_en = 1'b1; rule_wr_idx = IW'(idx);
    rule_wr_value = v; rule_wr_mask = m; rule_wr_enable = en;
    m_val[idx] = v; m_mask[idx] = m; m_en[idx] = en;
    @(negedge clk);
    rule_wr_en = 1'b0;
  endtask

  // R3 R4 R5 R6 R7: expected verdict from the bench's own rule table
  task automatic expect_verdict(input logic [REC_W-1:0] rec, input bit anom, input bit vld,
                                output bit mt, output int id, output bit prot);
    mt = 0; id = 0;
    if (!anom) begin
      for (int i = NR - 1; i >= 0; i--) begin
        if (m_en[i] && ((rec & m_mask[i]) == (m_val[i] & m_mask[i]))) begin
          mt = 1; id = i;
        end
      end
    end
    prot = !(!mt && !anom && vld);
  endtask

  task automatic send_record(input logic [REC_W-1:0] rec, input bit anom, input bit vld,
                             output bit prot);
    bit mt; int id;
    expect_verdict(rec, anom, vld, mt, id, prot);
    hdr_record = rec; hdr_anomaly = anom; hdr_valid = vld; hdr_strobe = 1'b1;
    @(negedge clk);
    hdr_strobe = 1'b0;
    check(res_strobe == 1'b1, "R9 strobe", res_strobe, 1);
    if (anom) check(res_matched == 0 && res_match_id == 0, "R7 skip", res_match_id, 0);
    else if (mt) check(res_matched == 1 && res_match_id == IW'(id), "R5 match id", res_match_id, id);
    else check(res_matched == 0 && res_match_id == 0, "R6 no hit", res_matched, 0);
    check(res_protect == prot, "R8 protect", res_protect, prot);
    @(negedge clk);
    check(res_strobe == 1'b0 && res_protect == prot, "R9 hold", res_strobe, 0);
  endtask

  task automatic send_payload(input int beats, input bit prot, input logic [DW-1:0] seed);
    for (int b = 0; b < beats; b++) begin
      logic [DW-1:0] d;
      d = seed ^ (DW'(b) * 64'h9E37_79B9_7F4A_7C15);
      pl_in_valid = 1'b1; pl_in_data = d; pl_in_last = (b == beats - 1);
      @(negedge clk);
      check(pl_out_valid == 1'b1 && pl_out_last == (b == beats - 1), "R10 framing",
            pl_out_last, (b == beats - 1));
      check(pl_out_data == (prot ? '0 : d), "R10 data", pl_out_data, prot ? 0 : d);
    end
    pl_in_valid = 1'b0; pl_in_last = 1'b0;
    @(negedge clk);
    check(pl_out_valid == 1'b0, "R10 idle after packet", pl_out_valid, 0);
  endtask

  initial begin
    bit prot;
    for (int i = 0; i < NR; i++) begin m_val[i] = '0; m_mask[i] = '0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(res_strobe == 0 && res_matched == 0 && res_match_id == 0, "R1 reset verdict",
          res_match_id, 0);
    check(res_protect == 1 && pl_out_valid == 0, "R1 reset protect", res_protect, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 beats before any verdict are zeroed
    send_payload(2, 1'b1, 64'hDEAD_BEEF_0123_4567);
    // R2 R4: all slots disabled after reset, nothing hits
    send_record({8'hAB, 104'h0, 8'h01}, 0, 1, prot);
    check(res_matched == 0, "R4 reset slots disabled", res_matched, 0);

    // program rules: slot k matches low byte k+1; slot 3 disabled;
    // slot 19 (top) matches top byte 0xAB; slot 8 low nibble wildcard (0x3_)
    for (int k = 0; k < NR; k++) begin
      logic [REC_W-1:0] v, m;
      v = '0; m = '0;
      if (k == NR - 1) begin v[119:112] = 8'hAB; m[119:112] = 8'hFF; end
      else if (k == 8) begin v[7:0] = 8'h30; m[7:0] = 8'hF0; end
      else begin v[7:0] = 8'(k + 1); m[7:0] = 8'hFF; end
      write_rule(k, v, m, k != 3);
    end
    // R2: a rule written is active for the next record
    send_record({8'h00, 104'h0, 8'h02}, 0, 1, prot);
    check(res_matched == 1 && res_match_id == 1, "R2 written rule active", res_match_id, 1);

    // sweep: low byte x top byte x anomaly x valid (R3 R4 R5 R6 R7 R8)
    for (int lo = 0; lo < 64; lo++) begin
      for (int t = 0; t < 2; t++) begin
        for (int c = 0; c < 4; c++) begin
          logic [REC_W-1:0] rec;
          rec = {t ? 8'hAB : 8'h5A, 104'(lo * 32'h01F3_5A17 + c), 8'(lo)};
          send_record(rec, c[1], c[0], prot);
          if (lo < 6 && t == 0) send_payload(3, prot, 64'(lo * 977 + c));
        end
      end
    end
    // R5 priority: low 0x05 (slot 4) and top 0xAB (slot 19) -> 4
    send_record({8'hAB, 104'h0, 8'h05}, 0, 1, prot);
    check(res_match_id == 4, "R5 lowest index wins", res_match_id, 4);
    // R5 top slot alone
    send_record({8'hAB, 104'h0, 8'hF0}, 0, 1, prot);
    check(res_match_id == NR - 1, "R5 top slot", res_match_id, NR - 1);
    // R4 disabled slot 3 (value 0x04) does not hit
    send_record({8'h00, 104'h0, 8'h04}, 0, 1, prot);
    check(res_matched == 0, "R4 disabled slot", res_matched, 0);
    // R3 wildcard nibble
    send_record({8'h00, 104'h0, 8'h3C}, 0, 1, prot);
    check(res_match_id == 8, "R3 wildcard bits", res_match_id, 8);
    // R10 forwarding after a clean verdict, then blocking after anomaly
    send_record({8'h00, 104'h0, 8'hEE}, 0, 1, prot);
    send_payload(4, 1'b0, 64'h0F0F_1234_5678_9ABC);
    send_record({8'h00, 104'h0, 8'hEE}, 1, 1, prot);
    send_payload(4, 1'b1, 64'h0F0F_1234_5678_9ABC);
    done = 1;
    finish_run();
  end
endmodule